// File: doc/BRIEF.md
# Differential Power Trace Accumulator

This block builds a differential trace for one key-guess hypothesis from many captured encryption runs. Each run produces a trace of digitised supply-current samples. Before the run's first sample arrives, an external selection function supplies one hypothesis bit. That bit places the whole trace in partition 1 or partition 0. The block keeps a running sum for every sample position in each partition, and a count of runs in each partition.

After the last run, the block steps through the sample positions in order. For each position it forms both partition means with a pair of multi-cycle restoring dividers, then emits the partition-1 mean minus the partition-0 mean as a signed value with a valid strobe. A large value at some position shows that the hypothesis correlates with the current drawn at that moment.

Software sets the trace length and the run count with a start pulse, feeds the hypothesis bits and samples, and waits for the done flag. If every run lands in one partition, the block emits zeros and raises a flag.

Top module: `dom_trace_accum`

## Requirements
- R1: After reset, `done`, `empty_flag` and `diff_valid` are all 0.
- R2: A `start` pulse loads the trace length `cfg_k` (1 to MAX_K) and the run count `cfg_m` (1 to MAX_RUNS). It clears `done` and `empty_flag`. After it, each cycle with `smp_valid` high takes one sample. Samples fill positions 0 to k-1 of run 0, then the same positions of run 1, and so on; idle cycles between samples are allowed.
- R3: A run's partition is the value of `sel_bit` at the most recent `sel_valid` strictly before that run's first sample (1 = partition 1, 0 = partition 0). A `sel_valid` in the same cycle as any sample of a run, including its last sample, affects only later runs.
- R4: Per-position sums do not overflow for up to 4096 runs of 12-bit samples, including 4095 runs that all carry the value 4095.
- R5: After the last sample of the last run, the block emits exactly k strobes on `diff_valid`, with `diff_idx` taking the values 0, 1, ..., k-1 in that order. Each `diff_data` is floor(sum1/n1) - floor(sum0/n0) for that position, as a 13-bit two's-complement number.
- R6: If either partition holds no runs, all k emitted values are 0, and `empty_flag` goes high and stays high until the next `start`.
- R7: `done` rises in the cycle that the last strobe appears and stays high until the next `start`; no strobe follows it.
- R8: `smp_valid` pulses before a `start`, during the output phase or after `done` have no effect on any emitted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new hypothesis, loads configuration |
| cfg_k | input | 5 | Samples per trace |
| cfg_m | input | 13 | Number of runs |
| sel_valid | input | 1 | Strobe for a new hypothesis bit |
| sel_bit | input | 1 | Partition for the next run |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Unsigned current sample |
| diff_valid | output | 1 | Differential entry strobe |
| diff_idx | output | 4 | Sample position of the entry |
| diff_data | output | 13 | Signed mean difference |
| done | output | 1 | All entries emitted |
| empty_flag | output | 1 | One partition had no runs |

## Verification
The case that needs care is the hypothesis strobe landing in the same cycle as the last sample of the previous run. That sample must still go to the old partition, and the new bit must steer only the next run. The driver puts every bit after the first into that shared cycle. The scoreboard's expected means, computed with each run's own partition, then judge the result. A second overlap is stray samples arriving while the dividers are running; the scoreboard shows that the emitted values stay unchanged.

// File: rtl/dom_pkg.sv
package dom_pkg;
    localparam int SAMPLE_W_DEF = 12;
    localparam int MAX_K_DEF    = 16;
    localparam int MAX_RUNS_DEF = 4096;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACC    = 2'd1,
        S_LAUNCH = 2'd2,
        S_WAIT   = 2'd3
    } dom_state_t;

    function automatic int sum_width(input int sw, input int runs);
        return sw + $clog2(runs + 1);
    endfunction
endpackage

// File: rtl/dom_acc_bank.sv
module dom_acc_bank #(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 16,
    parameter int MAX_RUNS = 4096,
    parameter int SUM_W    = 25,
    parameter int RUN_W    = 13,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                first_run,
    input  logic                run_head,
    input  logic                mine,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [SUM_W-1:0]    rd_sum,
    output logic [RUN_W-1:0]    run_count
);
    logic [SUM_W-1:0] sums [DEPTH];
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] addend;

    assign base   = first_run ? '0 : sums[wr_idx];
    assign addend = mine ? SUM_W'(wr_data) : '0;
    assign rd_sum = sums[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) sums[wr_idx] <= base + addend;
    end

    always_ff @(posedge clk) begin
        if (rst) run_count <= '0;
        else if (wr_en && run_head)
            run_count <= (first_run ? '0 : run_count) + RUN_W'(mine);
    end

    // R4: run count never passes the supported limit
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        run_count <= RUN_W'(MAX_RUNS));
endmodule

// File: rtl/dom_restoring_div.sv
module dom_restoring_div #(
    parameter int NUM_W = 25,
    parameter int DEN_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             ready,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]   rem;
    logic [DEN_W-1:0] den_r;
    logic [CNT_W-1:0] steps;
    logic [DEN_W:0]   trial;
    logic             fits;

    assign trial = {rem[DEN_W-1:0], quo[NUM_W-1]};
    assign fits  = trial >= {1'b0, den_r};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            den_r <= '0;
            steps <= '0;
            quo   <= '0;
            ready <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (go) begin
                rem   <= '0;
                den_r <= den;
                quo   <= num;
                steps <= CNT_W'(NUM_W);
            end else if (steps != '0) begin
                rem   <= fits ? trial - {1'b0, den_r} : trial;
                quo   <= {quo[NUM_W-2:0], fits};
                steps <= steps - 1'b1;
                if (steps == CNT_W'(1)) ready <= 1'b1;
            end
        end
    end

    // R5: a finished division leaves a remainder below the divisor
    assert_rem_below_R5: assert property (@(posedge clk) disable iff (rst)
        ready |-> (rem < {1'b0, den_r}));
endmodule

// File: rtl/dom_trace_accum.sv
module dom_trace_accum
    import dom_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int MAX_K    = MAX_K_DEF,
    parameter int MAX_RUNS = MAX_RUNS_DEF,
    localparam int K_W     = $clog2(MAX_K + 1),
    localparam int IDX_W   = $clog2(MAX_K),
    localparam int RUN_W   = $clog2(MAX_RUNS + 1),
    localparam int SUM_W   = sum_width(SAMPLE_W, MAX_RUNS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [K_W-1:0]      cfg_k,
    input  logic [RUN_W-1:0]    cfg_m,
    input  logic                sel_valid,
    input  logic                sel_bit,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                diff_valid,
    output logic [IDX_W-1:0]    diff_idx,
    output logic [SAMPLE_W:0]   diff_data,
    output logic                done,
    output logic                empty_flag
);
    dom_state_t       state;
    logic [K_W-1:0]   k_r;
    logic [RUN_W-1:0] m_r;
    logic [IDX_W-1:0] idx;
    logic [RUN_W-1:0] run;
    logic [IDX_W-1:0] out_idx;
    logic             pend_sel;
    logic             run_sel;

    logic             take;
    logic             cur_sel;
    logic             last_smp;
    logic             last_run;
    logic             part_empty;
    logic             div_go;
    logic             emit;
    logic [SAMPLE_W:0] emit_val;
    logic             last_out;

    logic [SUM_W-1:0] sum_p  [2];
    logic [RUN_W-1:0] cnt_p  [2];
    logic [SUM_W-1:0] quo_p  [2];
    logic             rdy_p  [2];

    assign take       = (state == S_ACC) && smp_valid && !start;
    assign cur_sel    = (idx == '0) ? pend_sel : run_sel;
    assign last_smp   = K_W'(idx) == k_r - 1'b1;
    assign last_run   = run == m_r - 1'b1;
    assign part_empty = (cnt_p[0] == '0) || (cnt_p[1] == '0);
    assign div_go     = (state == S_LAUNCH) && !part_empty && !start;
    assign last_out   = K_W'(out_idx) == k_r - 1'b1;

    always_comb begin
        emit     = 1'b0;
        emit_val = '0;
        if (!start) begin
            if (state == S_LAUNCH && part_empty) begin
                emit = 1'b1;
            end else if (state == S_WAIT && rdy_p[0]) begin
                emit     = 1'b1;
                emit_val = $signed({1'b0, quo_p[1][SAMPLE_W-1:0]})
                         - $signed({1'b0, quo_p[0][SAMPLE_W-1:0]});
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_part
        dom_acc_bank #(
            .SAMPLE_W(SAMPLE_W), .DEPTH(MAX_K), .MAX_RUNS(MAX_RUNS),
            .SUM_W(SUM_W), .RUN_W(RUN_W), .IDX_W(IDX_W)
        ) u_bank (
            .clk(clk), .rst(rst), .wr_en(take), .wr_idx(idx),
            .wr_data(smp_data), .first_run(run == '0),
            .run_head(idx == '0), .mine(cur_sel == 1'(p)),
            .rd_idx(out_idx), .rd_sum(sum_p[p]), .run_count(cnt_p[p])
        );

        dom_restoring_div #(.NUM_W(SUM_W), .DEN_W(RUN_W)) u_div (
            .clk(clk), .rst(rst), .go(div_go), .num(sum_p[p]),
            .den(cnt_p[p]), .ready(rdy_p[p]), .quo(quo_p[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            k_r        <= '0;
            m_r        <= '0;
            idx        <= '0;
            run        <= '0;
            out_idx    <= '0;
            pend_sel   <= 1'b0;
            run_sel    <= 1'b0;
            done       <= 1'b0;
            empty_flag <= 1'b0;
            diff_valid <= 1'b0;
            diff_idx   <= '0;
            diff_data  <= '0;
        end else begin
            diff_valid <= 1'b0;
            if (sel_valid) pend_sel <= sel_bit;
            if (start) begin
                k_r        <= cfg_k;
                m_r        <= cfg_m;
                idx        <= '0;
                run        <= '0;
                out_idx    <= '0;
                done       <= 1'b0;
                empty_flag <= 1'b0;
                state      <= S_ACC;
            end else begin
                case (state)
                    S_ACC: if (take) begin
                        if (idx == '0) run_sel <= pend_sel;
                        if (last_smp) begin
                            idx <= '0;
                            if (last_run) state <= S_LAUNCH;
                            else          run   <= run + 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                    S_LAUNCH: if (!part_empty) state <= S_WAIT;
                              else empty_flag <= 1'b1;
                    default: ;
                endcase
                if (emit) begin
                    diff_valid <= 1'b1;
                    diff_idx   <= out_idx;
                    diff_data  <= emit_val;
                    if (last_out) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        out_idx <= out_idx + 1'b1;
                        state   <= S_LAUNCH;
                    end
                end
            end
        end
    end

    // order tracker for the output index check
    logic [IDX_W-1:0] prev_idx;
    logic             have_prev;
    always_ff @(posedge clk) begin
        if (rst || start) begin
            have_prev <= 1'b0;
            prev_idx  <= '0;
        end else if (diff_valid) begin
            have_prev <= 1'b1;
            prev_idx  <= diff_idx;
        end
    end

    assert_idx_order_R5: assert property (@(posedge clk) disable iff (rst)
        (diff_valid && have_prev) |-> (diff_idx == IDX_W'(prev_idx + 1'b1)));
    assert_empty_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (empty_flag && !start) |=> empty_flag);
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
    assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> !diff_valid);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!done && !empty_flag && !diff_valid));
endmodule

// File: tb/dom_trace_accum_bench.sv
module dom_trace_accum_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  cfg_k = '0;
    logic [12:0] cfg_m = '0;
    logic        sel_valid = 1'b0;
    logic        sel_bit = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        diff_valid;
    logic [3:0]  diff_idx;
    logic [12:0] diff_data;
    logic        done;
    logic        empty_flag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;
    int exp_val[$];
    int exp_idx[$];
    string exp_req[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dom_trace_accum u_dom_trace_accum (
        .clk(clk), .rst(rst), .start(start), .cfg_k(cfg_k), .cfg_m(cfg_m),
        .sel_valid(sel_valid), .sel_bit(sel_bit), .smp_valid(smp_valid),
        .smp_data(smp_data), .diff_valid(diff_valid), .diff_idx(diff_idx),
        .diff_data(diff_data), .done(done), .empty_flag(empty_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit sel_of(int mode, int t, int r);
        if (mode == 1) return 1'b1;
        if (mode == 2) return r != 0;
        return 1'(((r * 5 + t) >> 1) & 1);
    endfunction

    function automatic int smp_of(int mode, int t, int r, int i, bit s);
        if (mode == 2) return s ? 4095 : 0;
        if (mode == 1) return (r * i + 5) % 4096;
        return (r * 173 + i * 611 + t * 59 + (s ? 900 : 0)) % 4096;
    endfunction

    // monitor: pops expected entries as the design emits them
    always @(negedge clk) begin
        if (!rst && diff_valid) begin
            if (exp_val.size() == 0) begin
                check("R5 unexpected strobe", 1, 0);
            end else begin
                string rq;
                int ev;
                int ei;
                rq = exp_req.pop_front();
                ev = exp_val.pop_front();
                ei = exp_idx.pop_front();
                check({rq, " diff_data"}, $signed(diff_data), ev);
                check("R5 diff_idx", int'(diff_idx), ei);
            end
        end
    end

    task automatic run_trial(int t, int k, int m, int mode);
        longint s0[16];
        longint s1[16];
        int n0 = 0;
        int n1 = 0;
        bit is_empty;
        string rq;
        for (int i = 0; i < 16; i++) begin s0[i] = 0; s1[i] = 0; end
        for (int r = 0; r < m; r++) begin
            bit s = sel_of(mode, t, r);
            if (s) n1++; else n0++;
            for (int i = 0; i < k; i++) begin
                if (s) s1[i] += smp_of(mode, t, r, i, s);
                else   s0[i] += smp_of(mode, t, r, i, s);
            end
        end
        is_empty = (n0 == 0) || (n1 == 0);
        rq = is_empty ? "R6" : (mode == 2 ? "R4" : "R3");
        for (int i = 0; i < k; i++) begin
            exp_val.push_back(is_empty ? 0 : int'(s1[i] / n1) - int'(s0[i] / n0));
            exp_idx.push_back(i);
            exp_req.push_back(rq);
        end
        // R8: stray samples while idle
        @(negedge clk); smp_valid = 1; smp_data = 12'hABC;
        @(negedge clk); smp_valid = 0;
        @(negedge clk); start = 1; cfg_k = 5'(k); cfg_m = 13'(m);
        @(negedge clk); start = 0;
        check("R2 done cleared by start", int'(done), 0);
        sel_valid = 1; sel_bit = sel_of(mode, t, 0);
        @(negedge clk); sel_valid = 0;
        for (int r = 0; r < m; r++) begin
            for (int i = 0; i < k; i++) begin
                if ((r + i) % 3 == 1) begin
                    smp_valid = 0;
                    @(negedge clk);
                end
                smp_valid = 1;
                smp_data = 12'(smp_of(mode, t, r, i, sel_of(mode, t, r)));
                // R3: next bit shares the cycle of this run's last sample
                if (i == k - 1 && r < m - 1) begin
                    sel_valid = 1; sel_bit = sel_of(mode, t, r + 1);
                end
                @(negedge clk);
                sel_valid = 0;
            end
        end
        // R8: junk samples during the output phase
        while (!done) begin
            smp_valid = 1; smp_data = 12'hFFF;
            @(negedge clk);
        end
        smp_valid = 0;
        @(negedge clk);
        check("R7 done held", int'(done), 1);
        check("R6 empty_flag", int'(empty_flag), int'(is_empty));
        check("R5 all entries emitted", exp_val.size(), 0);
        check("R7 no strobe after done", int'(diff_valid), 0);
        // R8: samples after done
        smp_valid = 1; smp_data = 12'h123;
        @(negedge clk); smp_valid = 0;
        @(negedge clk);
        check("R8 quiet after done", int'(diff_valid), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 done after reset", int'(done), 0);
        check("R1 empty after reset", int'(empty_flag), 0);
        check("R1 valid after reset", int'(diff_valid), 0);
        run_trial(1, 4, 6, 0);
        run_trial(2, 16, 9, 0);
        run_trial(3, 3, 5, 1);
        run_trial(4, 1, 4096, 2);
        run_trial(5, 2, 1, 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule